// File: doc/BRIEF.md
# Hierarchical Tree Magnitude Comparator

This block decides which of two unsigned operands of equal width is larger, with no clock and no state. The operands are cut into 4-bit slices. Each slice resolves its own verdict with a per-bit look-ahead enable: the one position where the operands first disagree, counted from the top of the slice, is the only one allowed to vote. The slice verdicts, each a greater/less pair, are then folded by a tree of merge nodes. Each node takes up to four child verdicts, with the most significant child first. At the default 32-bit width there are eight slices, two 16-bit merges and one final merge.

A merge node relies on the fact that a child never reports greater and less at the same time. This lets it use a two-term rule per output instead of a full decode of both children. Equal operands give a quiet output (both flags low) at every level. The width is a parameter and must be a multiple of 4. The same structure scales to 128 bits and beyond by adding tree levels.

Top module: `mag_tree_cmp`

## Requirements
- R1: `gt_o` is 1 exactly when `a_i` is greater than `b_i`, with both read as unsigned integers.
- R2: `lt_o` is 1 exactly when `a_i` is less than `b_i`, with both read as unsigned integers.
- R3: When `a_i` equals `b_i`, both `gt_o` and `lt_o` are 0.
- R4: `gt_o` and `lt_o` are never 1 together, and neither is any slice verdict inside the tree.
- R5: Within each 4-bit slice, at most one look-ahead enable is high. The enable for bit i is high when bit i differs between the operands and every higher bit of that slice agrees. A single differing bit at any position 0..3 of a slice decides the result.
- R6: The most significant differing slice decides the result, whatever the lower slices say. For example, a higher slice with `a_i` ahead overrides lower slices that all favour `b_i`.
- R7: Operands that differ only in bit 0, or only in the top bit, are ordered correctly.
- R8: The width parameter `W` (a multiple of 4) sets the tree depth. A 128-bit build follows R1 to R7 with the same slices and merge nodes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First unsigned operand |
| b_i | input | W | Second unsigned operand |
| gt_o | output | 1 | High when a_i > b_i |
| lt_o | output | 1 | High when a_i < b_i |

## Verification
The bench sweeps a single differing bit across every position, in both directions, at 32 and 128 bits. A slice with a wrong look-ahead enable, or a merge that drops a child, then gives a flipped or silent verdict at that one position. It sets a higher slice against lower slices that all point the other way. A merge that lets a lower child override a decided higher one is caught there. Equal operands (all zeros, all ones, random) catch any tree that reports a verdict when there is no difference, and random operands compared with the language's relational operators cover everything else.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

  typedef struct packed {
    logic gt;
    logic lt;
  } verdict_t;

  // Fold a less significant verdict under a more significant one.
  // The upper verdict is assumed never to be (1,1).
  function automatic verdict_t fold_verdict(input verdict_t upper, input verdict_t lower);
    verdict_t r;
    r.gt = upper.gt | (~upper.lt & lower.gt);
    r.lt = upper.lt | (~upper.gt & lower.lt);
    return r;
  endfunction

  // Node count at tree level lv (level 0 = slices).
  function automatic int level_nodes(input int leaves, input int fanin, input int lv);
    int c;
    c = leaves;
    for (int i = 0; i < lv; i++) c = (c + fanin - 1) / fanin;
    return c;
  endfunction

  function automatic int tree_depth(input int leaves, input int fanin);
    int c;
    int d;
    c = leaves;
    d = 0;
    while (c > 1) begin
      c = (c + fanin - 1) / fanin;
      d++;
    end
    return d;
  endfunction

  // Index of the first node of level lv in the flat node vector.
  function automatic int level_base(input int leaves, input int fanin, input int lv);
    int s;
    s = 0;
    for (int i = 0; i < lv; i++) s += level_nodes(leaves, fanin, i);
    return s;
  endfunction

endpackage

// File: rtl/mtc_slice4.sv
module mtc_slice4 (
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  output logic [3:0] en_o,
  output logic       gt_o,
  output logic       lt_o
);
  logic [3:0] diff;
  assign diff = a_i ^ b_i;

  for (genvar i = 0; i < 4; i++) begin : g_bit
    if (i == 3) begin : g_top
      assign en_o[i] = diff[i];
    end else begin : g_low
      assign en_o[i] = diff[i] & ~|diff[3:i+1];
    end
  end

  assign gt_o = |(en_o & a_i);
  assign lt_o = |(en_o & b_i);
endmodule

// File: rtl/mtc_merge.sv
module mtc_merge #(
  parameter int FI = 4
) (
  input  logic [FI-1:0] gt_i,   // index FI-1 is most significant
  input  logic [FI-1:0] lt_i,
  output logic          gt_o,
  output logic          lt_o
);
  import mtc_pkg::*;

  verdict_t acc;

  always_comb begin
    acc = '0;
    for (int i = FI - 1; i >= 0; i--) begin
      acc = fold_verdict(acc, verdict_t'({gt_i[i], lt_i[i]}));
    end
  end

  assign gt_o = acc.gt;
  assign lt_o = acc.lt;
endmodule

// File: rtl/mag_tree_cmp.sv
module mag_tree_cmp #(
  parameter int W     = 32,
  parameter int FANIN = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         gt_o,
  output logic         lt_o
);
  import mtc_pkg::*;

  localparam int LEAVES = W / 4;
  localparam int DEPTH  = tree_depth(LEAVES, FANIN);
  localparam int TOTAL  = level_base(LEAVES, FANIN, DEPTH + 1);

  if (W % 4 != 0 || W < 4) begin : g_width_bad
    $error("mag_tree_cmp: W must be a positive multiple of 4");
  end

  // Named internal events, observed by the bound checker.
  logic [W-1:0]      leaf_en;
  logic [LEAVES-1:0] leaf_gt;
  logic [LEAVES-1:0] leaf_lt;

  // Flat node storage: level 0 nodes first, root last.
  logic [TOTAL-1:0]  node_gt;
  logic [TOTAL-1:0]  node_lt;

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    mtc_slice4 u_slice (
      .a_i (a_i[4*k +: 4]),
      .b_i (b_i[4*k +: 4]),
      .en_o(leaf_en[4*k +: 4]),
      .gt_o(leaf_gt[k]),
      .lt_o(leaf_lt[k])
    );
  end

  assign node_gt[LEAVES-1:0] = leaf_gt;
  assign node_lt[LEAVES-1:0] = leaf_lt;

  for (genvar lv = 1; lv <= DEPTH; lv++) begin : g_lvl
    localparam int PREV_N    = level_nodes(LEAVES, FANIN, lv - 1);
    localparam int CUR_N     = level_nodes(LEAVES, FANIN, lv);
    localparam int PREV_BASE = level_base(LEAVES, FANIN, lv - 1);
    localparam int CUR_BASE  = level_base(LEAVES, FANIN, lv);
    for (genvar j = 0; j < CUR_N; j++) begin : g_node
      localparam int REM = PREV_N - j * FANIN;
      localparam int FI  = (REM < FANIN) ? REM : FANIN;
      mtc_merge #(.FI(FI)) u_merge (
        .gt_i(node_gt[PREV_BASE + j*FANIN +: FI]),
        .lt_i(node_lt[PREV_BASE + j*FANIN +: FI]),
        .gt_o(node_gt[CUR_BASE + j]),
        .lt_o(node_lt[CUR_BASE + j])
      );
    end
  end

  assign gt_o = node_gt[TOTAL-1];
  assign lt_o = node_lt[TOTAL-1];
endmodule

// File: rtl/mag_tree_cmp_chk.sv
module mag_tree_cmp_chk #(
  parameter int W = 32
) (
  input logic [W-1:0]   a_i,
  input logic [W-1:0]   b_i,
  input logic           gt_o,
  input logic           lt_o,
  input logic [W-1:0]   leaf_en,
  input logic [W/4-1:0] leaf_gt,
  input logic [W/4-1:0] leaf_lt
);
  always_comb begin
    a_r1_gt_unsigned: assert (gt_o == (a_i > b_i));
    a_r2_lt_unsigned: assert (lt_o == (a_i < b_i));
    a_r3_equal_quiet: assert (!(a_i == b_i) || (!gt_o && !lt_o));
    a_r4_exclusive:   assert (!(gt_o && lt_o));
    for (int k = 0; k < W / 4; k++) begin
      a_r5_slice_onehot: assert ($onehot0(leaf_en[4*k +: 4]));
      a_r4_slice_exclusive: assert (!(leaf_gt[k] && leaf_lt[k]));
    end
  end
endmodule

bind mag_tree_cmp mag_tree_cmp_chk #(.W(W)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .gt_o   (gt_o),
  .lt_o   (lt_o),
  .leaf_en(leaf_en),
  .leaf_gt(leaf_gt),
  .leaf_lt(leaf_lt)
);

// File: tb/mag_tree_cmp_bench.sv
module mag_tree_cmp_bench;
  logic clk = 1'b0;
  always #4ns clk = ~clk;   // 125 MHz

  logic [31:0]  a32, b32;
  logic         gt32, lt32;
  logic [127:0] a128, b128;
  logic         gt128, lt128;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  mag_tree_cmp #(.W(32)) u_mag_tree_cmp (
    .a_i(a32), .b_i(b32), .gt_o(gt32), .lt_o(lt32)
  );

  mag_tree_cmp #(.W(128)) u_mag_tree_cmp_w128 (
    .a_i(a128), .b_i(b128), .gt_o(gt128), .lt_o(lt128)
  );

  // {a, b, expected gt, expected lt}
  localparam logic [65:0] VEC [10] = '{
    {32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0},
    {32'h0000_0001, 32'h0000_0000, 1'b1, 1'b0},
    {32'h0000_0000, 32'h0000_0001, 1'b0, 1'b1},
    {32'h8000_0000, 32'h0000_0000, 1'b1, 1'b0},
    {32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 1'b1},
    {32'h0000_000B, 32'h0000_000C, 1'b0, 1'b1},
    {32'h1000_0000, 32'h0FFF_FFFF, 1'b1, 1'b0},
    {32'h1234_5678, 32'h1234_5679, 1'b0, 1'b1},
    {32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0, 1'b1}
  };

  task automatic judge(input string req, input logic got_gt, input logic got_lt,
                       input logic exp_gt, input logic exp_lt);
    checks++;
    if (got_gt !== exp_gt || got_lt !== exp_lt) begin
      fails++;
      $display("FAIL %s: got gt=%b lt=%b, expected gt=%b lt=%b",
               req, got_gt, got_lt, exp_gt, exp_lt);
    end
  endtask

  task automatic try32(input string req, input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    #2ns;
    a32 = a;
    b32 = b;
    #2ns;
    judge(req, gt32, lt32, a > b, a < b);
  endtask

  task automatic try128(input string req, input logic [127:0] a, input logic [127:0] b);
    @(posedge clk);
    #2ns;
    a128 = a;
    b128 = b;
    #2ns;
    judge(req, gt128, lt128, a > b, a < b);
  endtask

  initial begin
    a32 = '0; b32 = '0; a128 = '0; b128 = '0;
    repeat (2) @(posedge clk);
    #2ns;
    // R3: quiet state with zero operands
    judge("R3 initial zeros 32", gt32, lt32, 1'b0, 1'b0);
    judge("R3 initial zeros 128", gt128, lt128, 1'b0, 1'b0);

    // Table walk: R1 R2 R3 R7
    for (int i = 0; i < 10; i++) begin
      @(posedge clk);
      #2ns;
      a32 = VEC[i][65:34];
      b32 = VEC[i][33:2];
      #2ns;
      judge($sformatf("R1/R2 table %0d", i), gt32, lt32, VEC[i][1], VEC[i][0]);
    end

    // R5 and R7: a single differing bit at every position, both directions
    for (int p = 0; p < 32; p++) begin
      logic [31:0] base;
      base = 32'hA5C3_0F69 & ~(32'h1 << p);
      try32("R5 single-bit a ahead", base | (32'h1 << p), base);
      try32("R5 single-bit b ahead", base, base | (32'h1 << p));
    end
    for (int p = 0; p < 128; p++) begin
      logic [127:0] base;
      base = {4{32'h3C5A_96E1}} & ~(128'h1 << p);
      try128("R8 single-bit a ahead", base | (128'h1 << p), base);
      try128("R8 single-bit b ahead", base, base | (128'h1 << p));
    end

    // R6: higher slice decides against all lower slices
    try32("R6 high slice wins a", 32'h2000_0000, 32'h1FFF_FFFF);
    try32("R6 high slice wins b", 32'h0F00_0000, 32'h1000_0000);
    try128("R6 high slice wins 128", {4'h9, 124'h0}, {4'h8, {124{1'b1}}});
    try128("R6 mid slice wins 128", {64'h0, 4'h2, 60'h0}, {64'h0, 4'h1, {60{1'b1}}});

    // R7: LSB-only and MSB-only differences at 128 bits
    try128("R7 lsb only", {127'h0, 1'b1}, 128'h0);
    try128("R7 msb only", 128'h0, {1'b1, 127'h0});
    try128("R3 all ones 128", {128{1'b1}}, {128{1'b1}});

    // R1 R2 R3 R4: random operands and random equal operands
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] x, y;
      x = $urandom;
      y = (n % 5 == 0) ? x : $urandom;
      try32("R1/R2/R4 random 32", x, y);
    end
    for (int n = 0; n < 1500; n++) begin
      logic [127:0] x, y;
      x = {$urandom, $urandom, $urandom, $urandom};
      y = (n % 5 == 0) ? x : {x[127:96] ^ (n % 3 == 0 ? 32'h0 : $urandom),
                              $urandom, $urandom, $urandom};
      try128("R8 random 128", x, y);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule